// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block keeps the burst configuration of a 32-bit synchronous DRAM controller and turns a starting column into the column address of every beat of a read or write burst. A mode strobe loads an 11-bit operation word. From that word the block takes the burst length, the burst ordering, the CAS latency and the write mode. A start strobe then supplies an 8-bit starting column and a read/write flag. From the next cycle on, the block presents one column per clock, raises a flag on the final beat and holds busy while the burst runs.

The block supports sequential and interleaved ordering, lengths 1, 2, 4 and 8, and full-page bursts that sweep the whole 256-column row. A stop input cuts a burst short. A new start abandons the running burst and takes its place immediately. The latched CAS latency and the write mode are offered to the surrounding command and data logic. Reserved codes, and mode writes attempted during a burst, are reported as errors.

Top module: `burst_col_seq`

## Requirements
- R1: Bits [2:0] of the mode word set the burst length: 000=1, 001=2, 010=4, 011=8 beats. A burst shows beat k on `col_o` k+1 cycles after the start edge. `last_o` is high on the final beat only, and `busy_o` is low in the cycle after the final beat.
- R2: With bit [3]=0 (sequential), beat k shows the start column plus k, taken modulo the burst length on the low log2(length) bits. The upper column bits stay equal to the start column.
- R3: With bit [3]=1 (interleaved), beat k shows the start column XOR k on the low log2(length) bits. The upper bits are unchanged.
- R4: Length code 111 with bit [3]=0 gives a full-page burst. The column counts up from the start column modulo 256, `last_o` never rises, and the burst runs until a stop or a new start.
- R5: A stop pulse during a burst makes `busy_o` low in the next cycle. A start in the same cycle takes priority over the stop.
- R6: A start during a burst abandons it. The next cycle shows beat 0 of the new burst at the new start column.
- R7: Bit [9]=1 makes every write burst a single beat, while read bursts keep the programmed length. `single_write_o` shows the latched bit.
- R8: Bits [6:4] appear on `cas_lat_o` from the cycle after the mode strobe. Any value other than 2 or 3 raises `mode_err_o`.
- R9: Length codes 100, 101 and 110, and code 111 with interleaved ordering, raise `mode_err_o`, and bursts then run as length 1.
- R10: A mode strobe while `busy_o` is high is ignored. The latched configuration is unchanged, and `mode_ign_o` pulses high for the one following cycle.
- R11: After reset, `busy_o`, `last_o`, `mode_err_o` and `mode_ign_o` are low, `single_write_o` is low and `cas_lat_o` is 3, with length 1 sequential.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Load the operation word |
| mode_word_i | input | 11 | Operation word |
| start_i | input | 1 | Begin a burst |
| start_write_i | input | 1 | 1 = write burst, 0 = read burst |
| start_col_i | input | 8 | Starting column |
| stop_i | input | 1 | End the running burst |
| col_o | output | 8 | Column address of the current beat |
| busy_o | output | 1 | Burst in progress, col_o valid |
| last_o | output | 1 | Current beat is the final one |
| cas_lat_o | output | 3 | Latched CAS latency field |
| single_write_o | output | 1 | Write bursts forced to one beat |
| mode_err_o | output | 1 | Latched word holds a reserved code |
| mode_ign_o | output | 1 | Mode strobe ignored during a burst |

## Verification
Every result is due exactly one clock edge after its cause. Beat k of a burst is visible k+1 cycles after the start edge. The mode outputs and `mode_ign_o` change at the edge that takes the strobe, and `busy_o` falls at the edge after the final beat or the stop. The bench drives inputs on the falling edge and samples all outputs at the next falling edge, so each check lands in the single cycle in which its result is due. The burst loops step one beat per falling edge against a column computed from the requirement's ordering rule.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {BL_1, BL_2, BL_4, BL_8, BL_FULL} blen_e;

  // mode word field positions
  localparam int BL_LSB = 0;
  localparam int ILV_BIT = 3;
  localparam int CL_LSB = 4;
  localparam int SWR_BIT = 9;

  function automatic logic [7:0] len_mask(blen_e len);
    case (len)
      BL_2:    len_mask = 8'h01;
      BL_4:    len_mask = 8'h03;
      BL_8:    len_mask = 8'h07;
      BL_FULL: len_mask = 8'hFF;
      default: len_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int MODE_W = 11,
  parameter logic [MODE_W-1:0] RESET_MODE = 11'h030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [MODE_W-1:0] word_i,
  input  logic              block_i,
  output blen_e             len_o,
  output logic              ilv_o,
  output logic [2:0]        cas_o,
  output logic              single_wr_o,
  output logic              err_o,
  output logic              ign_o
);
  logic [MODE_W-1:0] word_q;
  logic              ign_q;
  logic              bl_err;
  logic              cl_err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= RESET_MODE;
      ign_q  <= 1'b0;
    end else begin
      ign_q <= set_i & block_i;
      if (set_i && !block_i) word_q <= word_i;
    end
  end

  assign ilv_o       = word_q[ILV_BIT];
  assign cas_o       = word_q[CL_LSB +: 3];
  assign single_wr_o = word_q[SWR_BIT];
  assign ign_o       = ign_q;

  always_comb begin
    bl_err = 1'b0;
    case (word_q[BL_LSB +: 3])
      3'b000: len_o = BL_1;
      3'b001: len_o = BL_2;
      3'b010: len_o = BL_4;
      3'b011: len_o = BL_8;
      3'b111: begin
        len_o  = ilv_o ? BL_1 : BL_FULL;
        bl_err = ilv_o;
      end
      default: begin
        len_o  = BL_1;
        bl_err = 1'b1;
      end
    endcase
  end

  assign cl_err = (cas_o != 3'd2) && (cas_o != 3'd3);
  assign err_o  = bl_err | cl_err;

  p_mode_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && block_i) |=> ($stable(cas_o) && $stable(single_wr_o) && $stable(len_o)));
  p_ign_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && block_i) |=> ign_o);
  p_mode_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !block_i) |=> (cas_o == $past(word_i[CL_LSB +: 3])));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             stop_i,
  input  blen_e            len_i,
  input  logic             ilv_i,
  input  logic             single_wr_i,
  output logic [COL_W-1:0] col_o,
  output logic             last_o,
  output logic             busy_o
);
  logic             busy_q;
  logic             ilv_q;
  logic             full_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] low;
  blen_e            eff_len;
  logic [7:0]       eff_mask8;
  logic [COL_W-1:0] eff_mask;

  assign eff_len   = (write_i && single_wr_i) ? BL_1 : len_i;
  assign eff_mask8 = len_mask(eff_len);
  // full page covers the whole row regardless of width
  assign eff_mask  = (eff_len == BL_FULL) ? {COL_W{1'b1}} : COL_W'(eff_mask8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      ilv_q  <= ilv_i;
      full_q <= (eff_len == BL_FULL);
      base_q <= col_i;
      beat_q <= '0;
      mask_q <= eff_mask;
    end else if (busy_q) begin
      if (stop_i || last_o) busy_q <= 1'b0;
      else                  beat_q <= beat_q + 1'b1;
    end
  end

  assign low    = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);
  assign col_o  = (base_q & ~mask_q) | (low & mask_q);
  assign last_o = busy_q && !full_q && (beat_q == mask_q);
  assign busy_o = busy_q;

  p_start_col_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && col_o == $past(col_i)));
  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i && !start_i) |=> !busy_o);
  p_last_end_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !busy_o);
  p_full_run_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && full_q && !stop_i && !start_i) |=> busy_o);
  p_upper_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && !stop_i && !last_o) |=>
      ((col_o & ~mask_q) == $past(col_o & ~mask_q)));
  p_single_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && write_i && single_wr_i) |=> last_o);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int MODE_W = 11,
  parameter logic [MODE_W-1:0] RESET_MODE = 11'h030
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_set_i,
  input  logic [MODE_W-1:0] mode_word_i,
  input  logic              start_i,
  input  logic              start_write_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [2:0]        cas_lat_o,
  output logic              single_write_o,
  output logic              mode_err_o,
  output logic              mode_ign_o
);
  blen_e len;
  logic  ilv;
  logic  busy;

  burst_mode_reg #(
    .MODE_W     (MODE_W),
    .RESET_MODE (RESET_MODE)
  ) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (mode_set_i),
    .word_i      (mode_word_i),
    .block_i     (busy),
    .len_o       (len),
    .ilv_o       (ilv),
    .cas_o       (cas_lat_o),
    .single_wr_o (single_write_o),
    .err_o       (mode_err_o),
    .ign_o       (mode_ign_o)
  );

  burst_addr_gen #(
    .COL_W (COL_W)
  ) u_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .write_i     (start_write_i),
    .col_i       (start_col_i),
    .stop_i      (stop_i),
    .len_i       (len),
    .ilv_i       (ilv),
    .single_wr_i (single_write_o),
    .col_o       (col_o),
    .last_o      (last_o),
    .busy_o      (busy)
  );

  assign busy_o = busy;
endmodule

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_set_i = 1'b0;
  logic [10:0] mode_word_i = '0;
  logic        start_i = 1'b0;
  logic        start_write_i = 1'b0;
  logic [7:0]  start_col_i = '0;
  logic        stop_i = 1'b0;
  logic [7:0]  col_o;
  logic        busy_o, last_o, single_write_o, mode_err_o, mode_ign_o;
  logic [2:0]  cas_lat_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  burst_col_seq u_burst_col_seq (
    .clk_i (clk), .rst_ni (rst_ni),
    .mode_set_i (mode_set_i), .mode_word_i (mode_word_i),
    .start_i (start_i), .start_write_i (start_write_i),
    .start_col_i (start_col_i), .stop_i (stop_i),
    .col_o (col_o), .busy_o (busy_o), .last_o (last_o),
    .cas_lat_o (cas_lat_o), .single_write_o (single_write_o),
    .mode_err_o (mode_err_o), .mode_ign_o (mode_ign_o)
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: act %0d cycles exp < 20000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_col(logic [7:0] s, int k, logic [7:0] m, logic il);
    logic [7:0] lo;
    lo = il ? (s ^ 8'(k)) : (s + 8'(k));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic set_mode(logic [10:0] w);
    mode_set_i = 1'b1; mode_word_i = w;
    tick();
    mode_set_i = 1'b0;
  endtask

  task automatic run_burst(string req, logic [7:0] s, logic wr, int n,
                           logic [7:0] m, logic il);
    start_i = 1'b1; start_col_i = s; start_write_i = wr;
    tick();
    start_i = 1'b0; start_write_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk(req, busy_o, 1);
      chk(req, col_o, exp_col(s, k, m, il));
      chk(req, last_o, k == n - 1);
      tick();
    end
    chk(req, busy_o, 0);
  endtask

  task automatic t_reset();
    chk("R11 busy", busy_o, 0);
    chk("R11 last", last_o, 0);
    chk("R11 cas", cas_lat_o, 3);
    chk("R11 err", mode_err_o, 0);
    chk("R11 ign", mode_ign_o, 0);
    chk("R11 swr", single_write_o, 0);
    run_burst("R11 default length 1", 8'h5A, 1'b0, 1, 8'h00, 1'b0);
  endtask

  task automatic t_lengths();
    set_mode(11'h030); run_burst("R1 len1", 8'h77, 1'b0, 1, 8'h00, 1'b0);
    set_mode(11'h031); run_burst("R1 len2", 8'h11, 1'b0, 2, 8'h01, 1'b0);
    set_mode(11'h032); run_burst("R1 len4", 8'h2E, 1'b0, 4, 8'h03, 1'b0);
    set_mode(11'h033); run_burst("R1 len8", 8'hC0, 1'b0, 8, 8'h07, 1'b0);
  endtask

  task automatic t_seq_wrap();
    set_mode(11'h033); run_burst("R2 seq wrap8", 8'h35, 1'b0, 8, 8'h07, 1'b0);
    set_mode(11'h032); run_burst("R2 seq wrap4", 8'hFF, 1'b1, 4, 8'h03, 1'b0);
  endtask

  task automatic t_interleave();
    set_mode(11'h03B); run_burst("R3 ilv8", 8'h35, 1'b0, 8, 8'h07, 1'b1);
    set_mode(11'h03A); run_burst("R3 ilv4", 8'h92, 1'b0, 4, 8'h03, 1'b1);
    chk("R3 err clear", mode_err_o, 0);
  endtask

  task automatic t_full_page();
    set_mode(11'h037);
    start_i = 1'b1; start_col_i = 8'hFE;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < 300; k++) begin
      chk("R4 full busy", busy_o, 1);
      chk("R4 full col", col_o, 8'(8'hFE + k));
      chk("R4 full no last", last_o, 0);
      tick();
    end
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk("R4 full stopped", busy_o, 0);
  endtask

  task automatic t_stop();
    set_mode(11'h033);
    start_i = 1'b1; start_col_i = 8'h08;
    tick();
    start_i = 1'b0;
    chk("R5 beat0", col_o, 8'h08);
    tick();
    chk("R5 beat1", col_o, 8'h09);
    tick();
    chk("R5 beat2", col_o, 8'h0A);
    stop_i = 1'b1;
    tick();
    stop_i = 1'b0;
    chk("R5 busy after stop", busy_o, 0);
    chk("R5 last after stop", last_o, 0);
    // start beats stop in the same cycle
    set_mode(11'h032);
    start_i = 1'b1; start_col_i = 8'h40;
    tick();
    start_col_i = 8'h63; stop_i = 1'b1;
    tick();
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R5 start wins busy", busy_o, 1);
      chk("R5 start wins col", col_o, exp_col(8'h63, k, 8'h03, 1'b0));
      tick();
    end
    chk("R5 start wins end", busy_o, 0);
  endtask

  task automatic t_interrupt();
    set_mode(11'h032);
    start_i = 1'b1; start_col_i = 8'h20;
    tick();
    start_i = 1'b0;
    chk("R6 old beat0", col_o, 8'h20);
    tick();
    chk("R6 old beat1", col_o, 8'h21);
    start_i = 1'b1; start_col_i = 8'h47;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R6 new col", col_o, exp_col(8'h47, k, 8'h03, 1'b0));
      chk("R6 new last", last_o, k == 3);
      tick();
    end
    chk("R6 done", busy_o, 0);
  endtask

  task automatic t_single_write();
    set_mode(11'h232);
    chk("R7 flag", single_write_o, 1);
    run_burst("R7 write single", 8'h50, 1'b1, 1, 8'h00, 1'b0);
    run_burst("R7 read full len", 8'h52, 1'b0, 4, 8'h03, 1'b0);
    set_mode(11'h032);
    chk("R7 flag off", single_write_o, 0);
    run_burst("R7 write burst", 8'h50, 1'b1, 4, 8'h03, 1'b0);
  endtask

  task automatic t_cas();
    set_mode(11'h022);
    chk("R8 cas2", cas_lat_o, 2);
    chk("R8 cas2 err", mode_err_o, 0);
    set_mode(11'h012);
    chk("R8 cas1", cas_lat_o, 1);
    chk("R8 cas1 err", mode_err_o, 1);
    set_mode(11'h042);
    chk("R8 cas4 err", mode_err_o, 1);
  endtask

  task automatic t_reserved_len();
    set_mode(11'h035);
    chk("R9 code101 err", mode_err_o, 1);
    run_burst("R9 code101 len1", 8'h33, 1'b0, 1, 8'h00, 1'b0);
    set_mode(11'h03F);
    chk("R9 full ilv err", mode_err_o, 1);
    run_burst("R9 full ilv len1", 8'h81, 1'b0, 1, 8'h00, 1'b0);
    set_mode(11'h030);
    chk("R9 err clears", mode_err_o, 0);
  endtask

  task automatic t_mode_ignore();
    set_mode(11'h033);
    start_i = 1'b1; start_col_i = 8'h00;
    tick();
    start_i = 1'b0;
    mode_set_i = 1'b1; mode_word_i = 11'h220;
    tick();
    mode_set_i = 1'b0;
    chk("R10 ign pulse", mode_ign_o, 1);
    chk("R10 cas kept", cas_lat_o, 3);
    chk("R10 burst runs", col_o, 8'h01);
    tick();
    chk("R10 ign one cycle", mode_ign_o, 0);
    for (int k = 0; k < 10 && busy_o; k++) tick();
    chk("R10 cas after", cas_lat_o, 3);
    chk("R10 swr after", single_write_o, 0);
    run_burst("R10 len kept", 8'h18, 1'b1, 8, 8'h07, 1'b0);
  endtask

  initial begin
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_lengths();
    t_seq_wrap();
    t_interleave();
    t_full_page();
    t_stop();
    t_interrupt();
    t_single_write();
    t_cas();
    t_reserved_len();
    t_mode_ignore();
    finish_run();
  end
endmodule